// File: doc/BRIEF.md
# Fine-Grained Hardware Time-of-Day Counter

This block keeps the time used to stamp network packets for precision time synchronisation. The time has two parts: a 48-bit seconds count and a nanoseconds count that wraps at one billion. On every clock cycle it adds a programmed step. The step has a whole-nanosecond part and an 8-bit fraction in units of 1/256 ns. The fraction builds up in a hidden accumulator, so clock periods that are not a whole number of nanoseconds (5.3 ns, for example, set as 0x05 and 0x4C) keep their long-run accuracy.

Software can write an absolute time with a load strobe. It can also apply a one-shot signed offset, forward or backward, while the clock keeps running. A separate capture strobe freezes a copy of the current time for the packet path to read as a timestamp. The control loop that computes steps and offsets is outside this block.

Top module: `ptp_time_keeper`

## Requirements
- R1: After a synchronous reset, the seconds, the nanoseconds, the hidden fraction, the captured time and the capture-valid flag are all zero.
- R2: On a clock edge with neither the load strobe nor the offset strobe high, the nanoseconds advance by the whole-nanosecond step plus the carry out of the fraction accumulator.
- R3: The fraction accumulator is 8 bits wide and counts in 1/256 ns. When the sum exceeds 255 it carries one nanosecond. A load clears the fraction to zero. With a step of 0x05 / 0x4C, the nanoseconds after a load read 5 after one cycle, 21 after four cycles and 1356 after 256 cycles.
- R4: The nanoseconds stay below 1,000,000,000. Reaching or passing that value subtracts it and adds one to the seconds.
- R5: The seconds are 48 bits wide and are shown as a low 32-bit word and a high 16-bit word. A carry out of the low word goes into the high word.
- R6: A load strobe seen at a clock edge sets the time to the load inputs at that edge. The new value is visible in the next cycle, and no step is added at that edge.
- R7: An offset strobe with sign 0 adds the offset seconds and offset nanoseconds to the time. A nanosecond sum of one billion or more carries into the seconds. The result is visible in the next cycle, and no step is added at that edge.
- R8: An offset strobe with sign 1 subtracts the offset. When the offset nanoseconds exceed the current nanoseconds, one second is borrowed and the nanoseconds wrap up by one billion.
- R9: When the load strobe and the offset strobe are high at the same edge, the load wins and the offset is ignored.
- R10: A capture strobe seen at a clock edge stores the time as it was just before that edge. The capture-valid flag is high for exactly the next cycle, and the stored time holds until the next capture strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_ns | input | 8 | Whole nanoseconds added per cycle |
| step_frac | input | 8 | Fractional step in 1/256 ns |
| load_stb | input | 1 | Load absolute time |
| load_sec_lo | input | 32 | Seconds to load, low word |
| load_sec_hi | input | 16 | Seconds to load, high word |
| load_ns | input | 32 | Nanoseconds to load (below one billion) |
| adj_stb | input | 1 | Apply one-shot offset |
| adj_neg | input | 1 | Offset sign: 0 add, 1 subtract |
| adj_sec | input | 48 | Offset seconds |
| adj_ns | input | 32 | Offset nanoseconds (below one billion) |
| cap_stb | input | 1 | Capture current time |
| time_sec_lo | output | 32 | Running seconds, low word |
| time_sec_hi | output | 16 | Running seconds, high word |
| time_ns | output | 32 | Running nanoseconds |
| cap_sec_lo | output | 32 | Captured seconds, low word |
| cap_sec_hi | output | 16 | Captured seconds, high word |
| cap_ns | output | 32 | Captured nanoseconds |
| cap_valid | output | 1 | One-cycle pulse after a capture |

## Verification
The hardest case to reach from the ports is the low seconds word carrying into the high word. At a gigahertz-scale step that would take four billion simulated seconds. The bench gets there by loading 0xFFFFFFFF seconds and a nanosecond value just short of one billion, then stepping once. The suppressed increment on offset and load edges is checked the same way. The bench samples the time, raises the strobe, and confirms that the next value differs by exactly the offset and that the value after that includes one normal step again. The fraction carry is reached by running long enough for 256 fractional steps to add up exactly.

// File: rtl/ptp_tk_pkg.sv
package ptp_tk_pkg;
    localparam int SEC_W   = 48;
    localparam int NS_W    = 32;
    localparam int STEP_W  = 8;
    localparam int FRAC_W  = 8;
    localparam int SEC_LO_W = 32;
    localparam int SEC_HI_W = SEC_W - SEC_LO_W;
    localparam logic [NS_W-1:0] NS_ROLL = 32'd1_000_000_000;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } ptp_time_t;

    typedef enum logic [1:0] {
        UPD_STEP = 2'd0,
        UPD_LOAD = 2'd1,
        UPD_ADJ  = 2'd2
    } upd_sel_e;

    function automatic upd_sel_e pick_update(input logic ld, input logic adj);
        if (ld)       return UPD_LOAD;
        else if (adj) return UPD_ADJ;
        else          return UPD_STEP;
    endfunction
endpackage

// File: rtl/ptp_tk_stepper.sv
module ptp_tk_stepper
    import ptp_tk_pkg::*;
#(
    parameter int STEP_WIDTH = STEP_W,
    parameter int FRAC_WIDTH = FRAC_W
) (
    input  ptp_time_t              cur,
    input  logic [FRAC_WIDTH-1:0]  frac,
    input  logic [STEP_WIDTH-1:0]  inc_ns,
    input  logic [FRAC_WIDTH-1:0]  inc_frac,
    output ptp_time_t              nxt,
    output logic [FRAC_WIDTH-1:0]  nxt_frac
);
    localparam logic [NS_W:0] ROLL_X = {1'b0, NS_ROLL};

    logic [FRAC_WIDTH:0] fsum;
    logic [NS_W:0]       nsum;
    logic                wrap;

    always_comb begin
        fsum     = {1'b0, frac} + {1'b0, inc_frac};
        nxt_frac = fsum[FRAC_WIDTH-1:0];
        nsum     = {1'b0, cur.ns} + (NS_W+1)'(inc_ns) + (NS_W+1)'(fsum[FRAC_WIDTH]);
        wrap     = (nsum >= ROLL_X);
        nxt.ns   = wrap ? NS_W'(nsum - ROLL_X) : nsum[NS_W-1:0];
        nxt.sec  = cur.sec + SEC_W'(wrap);
    end
endmodule

// File: rtl/ptp_tk_adjuster.sv
module ptp_tk_adjuster
    import ptp_tk_pkg::*;
(
    input  ptp_time_t         cur,
    input  logic              neg,
    input  logic [SEC_W-1:0]  off_sec,
    input  logic [NS_W-1:0]   off_ns,
    output ptp_time_t         res
);
    localparam logic [NS_W:0] ROLL_X = {1'b0, NS_ROLL};

    logic [NS_W:0] up_sum;
    logic          up_wrap;
    logic          borrow;

    always_comb begin
        up_sum  = {1'b0, cur.ns} + {1'b0, off_ns};
        up_wrap = (up_sum >= ROLL_X);
        borrow  = (cur.ns < off_ns);
        if (!neg) begin
            res.ns  = up_wrap ? NS_W'(up_sum - ROLL_X) : up_sum[NS_W-1:0];
            res.sec = cur.sec + off_sec + SEC_W'(up_wrap);
        end else begin
            res.ns  = borrow ? (cur.ns + NS_ROLL - off_ns) : (cur.ns - off_ns);
            res.sec = cur.sec - off_sec - SEC_W'(borrow);
        end
    end
endmodule

// File: rtl/ptp_tk_capture.sv
module ptp_tk_capture
    import ptp_tk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      grab,
    input  ptp_time_t live,
    output ptp_time_t held,
    output logic      fresh
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held  <= '0;
            fresh <= 1'b0;
        end else begin
            fresh <= grab;
            if (grab) held <= live;
        end
    end
endmodule

// File: rtl/ptp_time_keeper.sv
module ptp_time_keeper
    import ptp_tk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [STEP_W-1:0]    step_ns,
    input  logic [FRAC_W-1:0]    step_frac,
    input  logic                 load_stb,
    input  logic [SEC_LO_W-1:0]  load_sec_lo,
    input  logic [SEC_HI_W-1:0]  load_sec_hi,
    input  logic [NS_W-1:0]      load_ns,
    input  logic                 adj_stb,
    input  logic                 adj_neg,
    input  logic [SEC_W-1:0]     adj_sec,
    input  logic [NS_W-1:0]      adj_ns,
    input  logic                 cap_stb,
    output logic [SEC_LO_W-1:0]  time_sec_lo,
    output logic [SEC_HI_W-1:0]  time_sec_hi,
    output logic [NS_W-1:0]      time_ns,
    output logic [SEC_LO_W-1:0]  cap_sec_lo,
    output logic [SEC_HI_W-1:0]  cap_sec_hi,
    output logic [NS_W-1:0]      cap_ns,
    output logic                 cap_valid
);
    ptp_time_t          now_q, stepped, adjusted, cap_t;
    logic [FRAC_W-1:0]  frac_q, frac_stepped;
    upd_sel_e           sel;

    ptp_tk_stepper u_step (
        .cur      (now_q),
        .frac     (frac_q),
        .inc_ns   (step_ns),
        .inc_frac (step_frac),
        .nxt      (stepped),
        .nxt_frac (frac_stepped)
    );

    ptp_tk_adjuster u_adj (
        .cur     (now_q),
        .neg     (adj_neg),
        .off_sec (adj_sec),
        .off_ns  (adj_ns),
        .res     (adjusted)
    );

    ptp_tk_capture u_cap (
        .clk   (clk),
        .rst   (rst),
        .grab  (cap_stb),
        .live  (now_q),
        .held  (cap_t),
        .fresh (cap_valid)
    );

    assign sel = pick_update(load_stb, adj_stb);

    always_ff @(posedge clk) begin
        if (rst) begin
            now_q  <= '0;
            frac_q <= '0;
        end else begin
            unique case (sel)
                UPD_LOAD: begin
                    now_q.sec <= {load_sec_hi, load_sec_lo};
                    now_q.ns  <= load_ns;
                    frac_q    <= '0;
                end
                UPD_ADJ:  now_q <= adjusted;
                default: begin
                    now_q  <= stepped;
                    frac_q <= frac_stepped;
                end
            endcase
        end
    end

    assign time_sec_lo = now_q.sec[SEC_LO_W-1:0];
    assign time_sec_hi = now_q.sec[SEC_W-1:SEC_LO_W];
    assign time_ns     = now_q.ns;
    assign cap_sec_lo  = cap_t.sec[SEC_LO_W-1:0];
    assign cap_sec_hi  = cap_t.sec[SEC_W-1:SEC_LO_W];
    assign cap_ns      = cap_t.ns;
endmodule

// File: rtl/ptp_time_keeper_chk.sv
module ptp_time_keeper_chk
    import ptp_tk_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 load_stb,
    input logic [SEC_LO_W-1:0]  load_sec_lo,
    input logic [SEC_HI_W-1:0]  load_sec_hi,
    input logic [NS_W-1:0]      load_ns,
    input logic                 adj_stb,
    input logic                 adj_neg,
    input logic [SEC_W-1:0]     adj_sec,
    input logic [NS_W-1:0]      adj_ns,
    input logic                 cap_stb,
    input logic [SEC_LO_W-1:0]  time_sec_lo,
    input logic [SEC_HI_W-1:0]  time_sec_hi,
    input logic [NS_W-1:0]      time_ns,
    input logic [SEC_LO_W-1:0]  cap_sec_lo,
    input logic [SEC_HI_W-1:0]  cap_sec_hi,
    input logic [NS_W-1:0]      cap_ns,
    input logic                 cap_valid
);
    logic [SEC_W-1:0] sec_now;
    assign sec_now = {time_sec_hi, time_sec_lo};

    assert_ns_range_R4: assert property (@(posedge clk) disable iff (rst)
        time_ns < NS_ROLL);

    assert_sec_monotonic_R5: assert property (@(posedge clk) disable iff (rst)
        (!load_stb && !adj_stb) |=>
            (sec_now == $past(sec_now) || sec_now == $past(sec_now) + 48'd1));

    assert_load_value_R6: assert property (@(posedge clk) disable iff (rst)
        load_stb |=> (time_ns == $past(load_ns) &&
                      time_sec_lo == $past(load_sec_lo) &&
                      time_sec_hi == $past(load_sec_hi)));

    assert_zero_adj_freezes_R7: assert property (@(posedge clk) disable iff (rst)
        (adj_stb && !load_stb && adj_sec == '0 && adj_ns == '0) |=>
            ($stable(time_ns) && $stable(sec_now)));

    assert_capture_take_R10: assert property (@(posedge clk) disable iff (rst)
        cap_stb |=> (cap_valid && cap_ns == $past(time_ns) &&
                     cap_sec_lo == $past(time_sec_lo) &&
                     cap_sec_hi == $past(time_sec_hi)));

    assert_capture_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !cap_stb |=> (!cap_valid && $stable(cap_ns) &&
                      $stable(cap_sec_lo) && $stable(cap_sec_hi)));
endmodule

bind ptp_time_keeper ptp_time_keeper_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .load_stb    (load_stb),
    .load_sec_lo (load_sec_lo),
    .load_sec_hi (load_sec_hi),
    .load_ns     (load_ns),
    .adj_stb     (adj_stb),
    .adj_neg     (adj_neg),
    .adj_sec     (adj_sec),
    .adj_ns      (adj_ns),
    .cap_stb     (cap_stb),
    .time_sec_lo (time_sec_lo),
    .time_sec_hi (time_sec_hi),
    .time_ns     (time_ns),
    .cap_sec_lo  (cap_sec_lo),
    .cap_sec_hi  (cap_sec_hi),
    .cap_ns      (cap_ns),
    .cap_valid   (cap_valid)
);

// File: tb/ptp_time_keeper_tb_top.sv
module ptp_time_keeper_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  step_ns = '0, step_frac = '0;
    logic        load_stb = 1'b0, adj_stb = 1'b0, adj_neg = 1'b0, cap_stb = 1'b0;
    logic [31:0] load_sec_lo = '0, load_ns = '0, adj_ns = '0;
    logic [15:0] load_sec_hi = '0;
    logic [47:0] adj_sec = '0;
    logic [31:0] time_sec_lo, time_ns, cap_sec_lo, cap_ns;
    logic [15:0] time_sec_hi, cap_sec_hi;
    logic        cap_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    ptp_time_keeper dut_i (
        .clk(clk), .rst(rst), .step_ns(step_ns), .step_frac(step_frac),
        .load_stb(load_stb), .load_sec_lo(load_sec_lo), .load_sec_hi(load_sec_hi),
        .load_ns(load_ns), .adj_stb(adj_stb), .adj_neg(adj_neg), .adj_sec(adj_sec),
        .adj_ns(adj_ns), .cap_stb(cap_stb), .time_sec_lo(time_sec_lo),
        .time_sec_hi(time_sec_hi), .time_ns(time_ns), .cap_sec_lo(cap_sec_lo),
        .cap_sec_hi(cap_sec_hi), .cap_ns(cap_ns), .cap_valid(cap_valid)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] sec_now();
        return {time_sec_hi, time_sec_lo};
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_load(input logic [47:0] s, input logic [31:0] ns);
        load_sec_lo = s[31:0];
        load_sec_hi = s[47:32];
        load_ns     = ns;
        load_stb    = 1'b1;
        cyc(1);
        load_stb    = 1'b0;
    endtask

    task automatic do_adj(input logic neg, input logic [47:0] s, input logic [31:0] ns);
        adj_neg = neg;
        adj_sec = s;
        adj_ns  = ns;
        adj_stb = 1'b1;
        cyc(1);
        adj_stb = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 ns", {32'd0, time_ns}, 64'd0);
        check("R1 sec", {16'd0, sec_now()}, 64'd0);
        check("R1 cap", {cap_ns, 31'd0, cap_valid}, 64'd0);
    endtask

    task automatic t_integer_step;
        step_ns = 8'd8; step_frac = 8'd0;
        do_load(48'd0, 32'd0);
        cyc(10);
        check("R2 integer step", {32'd0, time_ns}, 64'd80);
    endtask

    task automatic t_fraction;
        step_ns = 8'h05; step_frac = 8'h4C;
        do_load(48'd0, 32'd0);
        check("R3 load clears", {32'd0, time_ns}, 64'd0);
        cyc(1);
        check("R3 one step", {32'd0, time_ns}, 64'd5);
        cyc(3);
        check("R3 fraction carry", {32'd0, time_ns}, 64'd21);
        cyc(252);
        check("R3 256 steps", {32'd0, time_ns}, 64'd1356);
    endtask

    task automatic t_rollover;
        step_ns = 8'd4; step_frac = 8'd0;
        do_load({16'h1234, 32'd5}, 32'd999_999_990);
        check("R6 load no step", {32'd0, time_ns}, 64'd999_999_990);
        cyc(2);
        check("R4 before wrap", {32'd0, time_ns}, 64'd999_999_998);
        cyc(1);
        check("R4 ns wrap", {32'd0, time_ns}, 64'd2);
        check("R4 sec carry", {16'd0, sec_now()}, {16'd0, 16'h1234, 32'd6});
    endtask

    task automatic t_word_carry;
        step_ns = 8'd4; step_frac = 8'd0;
        do_load({16'h0001, 32'hFFFF_FFFF}, 32'd999_999_996);
        cyc(1);
        check("R5 low word", {32'd0, time_sec_lo}, 64'd0);
        check("R5 high word", {48'd0, time_sec_hi}, 64'd2);
        check("R5 ns", {32'd0, time_ns}, 64'd0);
    endtask

    task automatic t_offsets;
        step_ns = 8'd0; step_frac = 8'd0;
        do_load(48'd10, 32'd900_000_000);
        do_adj(1'b0, 48'd2, 32'd200_000_000);
        check("R7 add ns", {32'd0, time_ns}, 64'd100_000_000);
        check("R7 add sec", {16'd0, sec_now()}, 64'd13);
        do_adj(1'b1, 48'd1, 32'd300_000_000);
        check("R8 sub ns", {32'd0, time_ns}, 64'd800_000_000);
        check("R8 sub sec", {16'd0, sec_now()}, 64'd11);
    endtask

    task automatic t_adj_suppress;
        step_ns = 8'd10; step_frac = 8'd0;
        do_load(48'd0, 32'd1000);
        do_adj(1'b0, 48'd0, 32'd5);
        check("R7 no step on offset", {32'd0, time_ns}, 64'd1005);
        cyc(1);
        check("R7 step resumes", {32'd0, time_ns}, 64'd1015);
    endtask

    task automatic t_priority;
        step_ns = 8'd0;
        adj_neg = 1'b0; adj_sec = 48'd3; adj_ns = 32'd7; adj_stb = 1'b1;
        do_load(48'd7, 32'd500);
        adj_stb = 1'b0;
        check("R9 load wins ns", {32'd0, time_ns}, 64'd500);
        check("R9 load wins sec", {16'd0, sec_now()}, 64'd7);
    endtask

    task automatic t_capture;
        logic [31:0] t_ns;
        logic [47:0] t_sec;
        step_ns = 8'd10; step_frac = 8'd0;
        do_load(48'h0002_0000_0009, 32'd400);
        cyc(3);
        t_ns = time_ns; t_sec = sec_now();
        cap_stb = 1'b1;
        cyc(1);
        cap_stb = 1'b0;
        check("R10 valid", {63'd0, cap_valid}, 64'd1);
        check("R10 cap ns", {32'd0, cap_ns}, {32'd0, t_ns});
        check("R10 cap sec", {16'd0, cap_sec_hi, cap_sec_lo}, {16'd0, t_sec});
        check("R10 live moved", {32'd0, time_ns}, {32'd0, t_ns + 32'd10});
        cyc(2);
        check("R10 valid drops", {63'd0, cap_valid}, 64'd0);
        check("R10 held", {32'd0, cap_ns}, {32'd0, t_ns});
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        t_reset();
        t_integer_step();
        t_fraction();
        t_rollover();
        t_word_carry();
        t_offsets();
        t_adj_suppress();
        t_priority();
        t_capture();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule